// File: doc/BRIEF.md
# Short-Address DMA Channel

This block is one DMA channel whose transfers always run between two addresses: a memory pointer that may step after each transfer and an I/O pointer that never moves. Software loads the two pointers, a transfer count and a control word through a small register port. Writing the control word with the arm bit set enables the channel. From then on, each rising edge on the chosen request line moves exactly one byte or one word across a single-beat bus master port. The move is a read beat followed by a write beat.

A direction bit sets which pointer is read and which is written. In sequential mode the memory pointer moves up or down by the unit size after every transfer. In idle mode it stays put, so every unit uses the same pair of addresses. When the count runs out, the channel disarms itself and raises a done flag. The done flag drives the interrupt output when the interrupt enable is set.

Top module: `sadma_channel`

## Requirements
- R1: An accepted request produces one read beat (`bus_rd` high) in the cycle after the accepting clock edge and one write beat (`bus_wr` high) in the next cycle. The two strobes are never high together.
- R2: Each write beat decrements the count register by one. The write beat that takes the count from 1 to 0 clears the arm bit (CTRL bit 0) and sets the done flag (CTRL bit 15). A count of 0 at arming means 2^CNT_W transfers.
- R3: With CTRL bit 5 set, the read beat uses the memory pointer and the write beat uses the I/O pointer. With bit 5 clear, the read beat uses the I/O pointer and the write beat uses the memory pointer. The data written is the data read.
- R4: In sequential mode the memory pointer steps after every transfer by 1 for bytes and 2 for words. It counts down when CTRL bit 3 is set and up otherwise, and it wraps modulo 2^ADDR_W.
- R5: Idle mode is selected when CTRL bit 2 (hold) and CTRL bit 1 (interrupt enable) are both set, and the memory pointer then keeps its value across transfers. With hold set and the interrupt enable clear, the channel runs in sequential mode.
- R6: When CTRL bit 4 is 0, a transfer moves a byte: `bus_wide` is low and only the low 8 data bits are carried, with the upper bits of `bus_wdata` at zero. When the bit is 1, `bus_wide` is high and the full data width is carried.
- R7: CTRL bits 11:8 select the request line. Only a rising edge of the selected line is a request.
- R8: A request is ignored and not queued if it arrives while the channel is disarmed or while a transfer is in progress.
- R9: While the channel is armed or a transfer is in progress, writes to the pointer and count registers have no effect, and a control-word write changes only the arm bit and the done-clear action.
- R10: `irq` equals the done flag AND the interrupt enable. Writing the control word with bit 15 set clears the done flag.
- R11: Register map on `cfg_addr`: 0 holds the memory pointer, 1 the I/O pointer, 2 the count and 3 the control word. After reset every register reads 0, and `irq`, `bus_rd` and `bus_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data (combinational) |
| req | input | NREQ | Transfer request lines |
| bus_addr | output | ADDR_W | Bus address of the current beat |
| bus_rd | output | 1 | Read beat strobe |
| bus_wr | output | 1 | Write beat strobe |
| bus_wide | output | 1 | Beat carries a word (1) or a byte (0) |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data returned in the read beat cycle |
| irq | output | 1 | Transfer-end interrupt |

## Verification
Call the clock edge that sees the selected request line rise the accepting edge. The read beat is visible in the cycle after that edge. The write beat, with its address and data, is visible one cycle later. The stepped pointer, the decremented count, the cleared arm bit and `irq` all appear after a third edge. Register writes take effect at the edge that follows the write strobe. The bench drives every input on the falling edge and samples at falling edges placed one, two and three cycles after the request is raised, so each result is read in the cycle it is due. The bus model returns data computed from the address, so the bench can check each write against the expected source.

// File: rtl/sadma_pkg.sv
// Shared definitions for the short-address DMA channel: register select
// codes, control-word bit positions, the channel configuration record and
// the transfer engine states. The register data path is fixed at CFG_W bits.
package sadma_pkg;

    localparam int CFG_W   = 16;
    localparam int SRC_W   = 4;

    // Control-word bit positions
    localparam int B_ARM   = 0;
    localparam int B_IE    = 1;
    localparam int B_HOLD  = 2;
    localparam int B_DOWN  = 3;
    localparam int B_WIDE  = 4;
    localparam int B_TOIO  = 5;
    localparam int B_SRC   = 8;
    localparam int B_DONE  = 15;

    typedef enum logic [1:0] {
        REG_MEM  = 2'd0,
        REG_IO   = 2'd1,
        REG_CNT  = 2'd2,
        REG_CTRL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic             ie;
        logic             hold;
        logic             down;
        logic             wide;
        logic             to_io;
        logic [SRC_W-1:0] src;
    } chan_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } xfer_st_e;

endpackage

// File: rtl/sadma_req_sel.sv
// Request selector: pads the request lines to the full select range, picks
// the line named by the source field and reports its rising edge for one
// cycle. Assumes the request lines are synchronous to clk.
module sadma_req_sel
    import sadma_pkg::*;
#(
    parameter int NREQ = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NREQ-1:0]  req,
    input  logic [SRC_W-1:0] src,
    output logic             req_edge
);

    localparam int NSEL = 1 << SRC_W;

    logic [NSEL-1:0] req_pad;
    logic            sel_now;
    logic            sel_q;

    // Lines above NREQ read as never requesting
    for (genvar i = 0; i < NSEL; i++) begin : g_pad
        if (i < NREQ) begin : g_live
            assign req_pad[i] = req[i];
        end else begin : g_dead
            assign req_pad[i] = 1'b0;
        end
    end

    // Pick the selected line
    always_comb sel_now = req_pad[src];

    // Remember last value of the selected line for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel_now;
    end

    // One-cycle pulse on a rising edge
    always_comb req_edge = sel_now & ~sel_q;

endmodule

// File: rtl/sadma_regs.sv
// Register bank: memory pointer, I/O pointer, transfer count and control
// word. Applies the per-transfer updates (pointer step, count decrement,
// end-of-count) and locks configuration while armed or busy.
// Assumes ADDR_W and CNT_W do not exceed CFG_W.
module sadma_regs
    import sadma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              busy,
    input  logic              xfer_done,
    output logic [ADDR_W-1:0] mem_ptr,
    output logic [ADDR_W-1:0] io_ptr,
    output logic [CNT_W-1:0]  xfer_cnt,
    output chan_cfg_t         cfg,
    output logic              arm,
    output logic              done,
    output logic              idle_mode
);

    localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);
    localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

    logic              locked;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] mem_next;
    logic              last_unit;
    chan_cfg_t         wr_cfg;
    reg_sel_e          sel;
    logic              unused_bits;

    // Configuration is frozen while armed or mid-transfer
    always_comb locked = arm | busy;

    // Decode the register select
    always_comb sel = reg_sel_e'(cfg_addr);

    // Next memory pointer in sequential mode
    always_comb begin
        step     = cfg.wide ? STEP_WORD : STEP_BYTE;
        mem_next = cfg.down ? (mem_ptr - step) : (mem_ptr + step);
    end

    // Final transfer of the programmed count
    always_comb last_unit = (xfer_cnt == CNT_ONE);

    // Idle mode needs both hold and interrupt enable
    always_comb idle_mode = cfg.hold & cfg.ie;

    // Unpack a control-word write into configuration fields
    always_comb begin
        wr_cfg.ie    = cfg_wdata[B_IE];
        wr_cfg.hold  = cfg_wdata[B_HOLD];
        wr_cfg.down  = cfg_wdata[B_DOWN];
        wr_cfg.wide  = cfg_wdata[B_WIDE];
        wr_cfg.to_io = cfg_wdata[B_TOIO];
        wr_cfg.src   = cfg_wdata[B_SRC +: SRC_W];
    end

    // Reserved control bits are accepted and discarded
    assign unused_bits = ^{cfg_wdata[B_DONE-1:B_SRC+SRC_W], cfg_wdata[B_SRC-1:B_TOIO+1]};

    // Register writes followed by per-transfer updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_ptr  <= '0;
            io_ptr   <= '0;
            xfer_cnt <= '0;
            cfg      <= '0;
            arm      <= 1'b0;
            done     <= 1'b0;
        end else begin
            if (cfg_we) begin
                case (sel)
                    REG_MEM:  if (!locked) mem_ptr  <= cfg_wdata[ADDR_W-1:0];
                    REG_IO:   if (!locked) io_ptr   <= cfg_wdata[ADDR_W-1:0];
                    REG_CNT:  if (!locked) xfer_cnt <= cfg_wdata[CNT_W-1:0];
                    REG_CTRL: begin
                        if (!locked) cfg <= wr_cfg;
                        arm <= cfg_wdata[B_ARM];
                        if (cfg_wdata[B_DONE]) done <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (xfer_done) begin
                if (!idle_mode) mem_ptr <= mem_next;
                xfer_cnt <= xfer_cnt - CNT_ONE;
                if (last_unit) begin
                    arm  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Read-back multiplexer
    always_comb begin
        cfg_rdata = '0;
        case (sel)
            REG_MEM:  cfg_rdata = CFG_W'(mem_ptr);
            REG_IO:   cfg_rdata = CFG_W'(io_ptr);
            REG_CNT:  cfg_rdata = CFG_W'(xfer_cnt);
            REG_CTRL: begin
                cfg_rdata[B_ARM]             = arm;
                cfg_rdata[B_IE]              = cfg.ie;
                cfg_rdata[B_HOLD]            = cfg.hold;
                cfg_rdata[B_DOWN]            = cfg.down;
                cfg_rdata[B_WIDE]            = cfg.wide;
                cfg_rdata[B_TOIO]            = cfg.to_io;
                cfg_rdata[B_SRC +: SRC_W]    = cfg.src;
                cfg_rdata[B_DONE]            = done;
            end
            default: cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sadma_xfer_fsm.sv
// Transfer engine: for each accepted request runs one read beat then one
// write beat on the single-beat bus, holding the read unit in between.
// Assumes the bus slave returns read data in the read beat cycle and that
// no beat is stretched.
module sadma_xfer_fsm
    import sadma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              arm,
    input  logic              wide,
    input  logic              to_io,
    input  logic [ADDR_W-1:0] mem_ptr,
    input  logic [ADDR_W-1:0] io_ptr,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_wide,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              busy,
    output logic              xfer_done
);

    localparam logic [DATA_W-1:0] BYTE_MASK = DATA_W'(8'hFF);

    xfer_st_e          state;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rd_unit;
    logic [ADDR_W-1:0] src_addr;
    logic [ADDR_W-1:0] dst_addr;

    // Sequence: idle, read beat, write beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start_req && arm) state <= ST_RD;
                ST_RD:   state <= ST_WR;
                ST_WR:   state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Trim the read data to the unit size
    always_comb rd_unit = wide ? bus_rdata : (bus_rdata & BYTE_MASK);

    // Hold the unit between the read and write beats
    always_ff @(posedge clk) begin
        if (!rst_n)              data_q <= '0;
        else if (state == ST_RD) data_q <= rd_unit;
    end

    // Source and destination from the direction bit
    always_comb begin
        src_addr = to_io ? mem_ptr : io_ptr;
        dst_addr = to_io ? io_ptr  : mem_ptr;
    end

    // Bus outputs per state
    always_comb begin
        bus_rd    = (state == ST_RD);
        bus_wr    = (state == ST_WR);
        busy      = (state != ST_IDLE);
        xfer_done = (state == ST_WR);
        bus_wide  = busy & wide;
        bus_wdata = (state == ST_WR) ? data_q : '0;
        case (state)
            ST_RD:   bus_addr = src_addr;
            ST_WR:   bus_addr = dst_addr;
            default: bus_addr = '0;
        endcase
    end

endmodule

// File: rtl/sadma_channel.sv
// Top of the short-address DMA channel: joins the request selector, the
// register bank and the transfer engine, and forms the interrupt.
// Assumes NREQ is at most 16 and ADDR_W and CNT_W are at most 16.
module sadma_channel
    import sadma_pkg::*;
#(
    parameter int NREQ   = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic [NREQ-1:0]   req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_wide,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    logic              req_edge;
    logic              busy;
    logic              xfer_done;
    logic [ADDR_W-1:0] mem_ptr;
    logic [ADDR_W-1:0] io_ptr;
    logic [CNT_W-1:0]  xfer_cnt;
    chan_cfg_t         cfg;
    logic              arm;
    logic              done;
    logic              idle_mode;

    sadma_req_sel #(.NREQ(NREQ)) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .src      (cfg.src),
        .req_edge (req_edge)
    );

    sadma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy),
        .xfer_done (xfer_done),
        .mem_ptr   (mem_ptr),
        .io_ptr    (io_ptr),
        .xfer_cnt  (xfer_cnt),
        .cfg       (cfg),
        .arm       (arm),
        .done      (done),
        .idle_mode (idle_mode)
    );

    sadma_xfer_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (req_edge),
        .arm       (arm),
        .wide      (cfg.wide),
        .to_io     (cfg.to_io),
        .mem_ptr   (mem_ptr),
        .io_ptr    (io_ptr),
        .bus_rdata (bus_rdata),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wide  (bus_wide),
        .bus_wdata (bus_wdata),
        .busy      (busy),
        .xfer_done (xfer_done)
    );

    // Interrupt is the done flag gated by its enable
    always_comb irq = done & cfg.ie;

endmodule

// File: rtl/sadma_checker.sv
// Property checker for the DMA channel, attached to every instance of the
// top module by the bind below. Observes the bus strobes and register state.
module sadma_checker #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] mem_ptr,
    input logic [CNT_W-1:0]  xfer_cnt,
    input logic              idle_mode,
    input logic              arm,
    input logic              done
);

    assert_read_then_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_wr);

    assert_beats_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    assert_no_queue_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> !bus_rd);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> (xfer_cnt == CNT_W'($past(xfer_cnt) - CNT_W'(1))));

    assert_done_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(bus_wr) && !arm));

    assert_hold_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && idle_mode) |=> $stable(mem_ptr));

    assert_lock_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !bus_wr) |=> $stable(mem_ptr));

endmodule

bind sadma_channel sadma_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .mem_ptr   (mem_ptr),
    .xfer_cnt  (xfer_cnt),
    .idle_mode (idle_mode),
    .arm       (arm),
    .done      (done)
);

// File: tb/sadma_channel_test.sv
module sadma_channel_test;

    localparam int NREQ = 16;
    localparam logic [15:0] PAT = 16'hA5C3;

    typedef struct packed {
        logic        hold;
        logic        ie;
        logic        down;
        logic        wide;
        logic        to_io;
        logic [3:0]  src;
        logic [15:0] mem;
        logic [15:0] io;
        logic [7:0]  n;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2,  16'h1000, 16'h0040, 8'd3},
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd5,  16'h2008, 16'h0080, 8'd4},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd0,  16'h3000, 16'h00C0, 8'd3},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 4'd15, 16'h40FE, 16'h0010, 8'd2},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7,  16'hFFFF, 16'h0020, 8'd2}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [1:0]      cfg_addr = 2'd0;
    logic [15:0]     cfg_wdata = '0;
    logic [15:0]     cfg_rdata;
    logic [NREQ-1:0] req = '0;
    logic [15:0]     bus_addr;
    logic            bus_rd;
    logic            bus_wr;
    logic            bus_wide;
    logic [15:0]     bus_wdata;
    logic [15:0]     bus_rdata;
    logic            irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    // Bus slave: read data is a function of the address
    assign bus_rdata = bus_addr ^ PAT;

    sadma_channel uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req(req),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [15:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    function automatic logic [15:0] ctrl_word(input logic arm, input logic ie,
            input logic hold, input logic down, input logic wide,
            input logic to_io, input logic [3:0] src, input logic clr);
        return {clr, 3'b000, src, 2'b00, to_io, wide, down, hold, ie, arm};
    endfunction

    // One request on a line; checks both beats at their due cycles
    task automatic do_xfer(input int line, input logic [15:0] ra,
                           input logic [15:0] wa, input logic [15:0] wd,
                           input logic wide);
        req[line] = 1'b1;
        @(negedge clk);
        chk("R1", "read strobe", 32'(bus_rd), 32'd1);
        chk("R3", "read address", 32'(bus_addr), 32'(ra));
        req[line] = 1'b0;
        @(negedge clk);
        chk("R1", "write strobe", 32'(bus_wr), 32'd1);
        chk("R3", "write address", 32'(bus_addr), 32'(wa));
        chk("R6", "write data", 32'(bus_wdata), 32'(wd));
        chk("R6", "size strobe", 32'(bus_wide), 32'(wide));
        chk("R10", "irq low during beat", 32'(irq), 32'd0);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        logic [15:0] rv;
        repeat (3) @(negedge clk);

        // Reset state (R11)
        chk("R11", "irq in reset", 32'(irq), 32'd0);
        chk("R11", "bus_rd in reset", 32'(bus_rd), 32'd0);
        chk("R11", "bus_wr in reset", 32'(bus_wr), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int r = 0; r < 4; r++) begin
            cfg_read(2'(r), rv);
            chk("R11", "register after reset", 32'(rv), 32'd0);
        end

        // Vector table walk
        for (int v = 0; v < 5; v++) begin
            vec_t        t;
            logic [15:0] m;
            logic [15:0] ra;
            logic [15:0] wa;
            logic [15:0] wd;
            logic [15:0] stp;
            t = VECS[v];
            m = t.mem;
            stp = t.wide ? 16'd2 : 16'd1;
            cfg_write(2'd3, ctrl_word(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1));
            cfg_write(2'd0, t.mem);
            cfg_write(2'd1, t.io);
            cfg_write(2'd2, 16'(t.n));
            cfg_write(2'd3, ctrl_word(1'b1, t.ie, t.hold, t.down, t.wide, t.to_io, t.src, 1'b0));
            for (int k = 0; k < int'(t.n); k++) begin
                ra = t.to_io ? m : t.io;
                wa = t.to_io ? t.io : m;
                wd = t.wide ? (ra ^ PAT) : ((ra ^ PAT) & 16'h00FF);
                do_xfer(int'(t.src), ra, wa, wd, t.wide);
                if (!(t.hold && t.ie)) m = t.down ? (m - stp) : (m + stp);
            end
            cfg_read(2'd0, rv);
            chk("R4", "memory pointer after run (R5 for idle mode)", 32'(rv), 32'(m));
            cfg_read(2'd2, rv);
            chk("R2", "count at end", 32'(rv), 32'd0);
            cfg_read(2'd3, rv);
            chk("R2", "arm cleared", 32'(rv[0]), 32'd0);
            chk("R2", "done set", 32'(rv[15]), 32'd1);
            chk("R10", "irq at end", 32'(irq), 32'(t.ie));
        end

        // Done clear by control write (R10); last vector left irq high
        cfg_write(2'd3, ctrl_word(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0, 1'b1));
        chk("R10", "irq after done clear", 32'(irq), 32'd0);

        // Disarmed channel ignores requests (R8)
        cfg_write(2'd0, 16'h5000);
        cfg_write(2'd1, 16'h0030);
        cfg_write(2'd2, 16'd5);
        cfg_write(2'd3, ctrl_word(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 1'b0));
        req[3] = 1'b1;
        @(negedge clk);
        chk("R8", "no read while disarmed", 32'(bus_rd), 32'd0);
        req[3] = 1'b0;
        repeat (2) @(negedge clk);
        cfg_read(2'd2, rv);
        chk("R8", "count kept while disarmed", 32'(rv), 32'd5);

        // Unselected line is not a request (R7)
        cfg_write(2'd3, ctrl_word(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 1'b0));
        req[4] = 1'b1;
        @(negedge clk);
        chk("R7", "no read on other line", 32'(bus_rd), 32'd0);
        req[4] = 1'b0;
        repeat (2) @(negedge clk);
        cfg_read(2'd2, rv);
        chk("R7", "count kept on other line", 32'(rv), 32'd5);

        // A level held high is one request only (R7)
        req[3] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7", "held level gives no second read", 32'(bus_rd), 32'd0);
        req[3] = 1'b0;
        @(negedge clk);
        cfg_read(2'd2, rv);
        chk("R7", "count after held level", 32'(rv), 32'd4);

        // Request edge during write beat is dropped (R8)
        req[3] = 1'b1;
        @(negedge clk);
        chk("R1", "read beat", 32'(bus_rd), 32'd1);
        req[3] = 1'b0;
        @(negedge clk);
        chk("R1", "write beat", 32'(bus_wr), 32'd1);
        req[3] = 1'b1;
        @(negedge clk);
        chk("R8", "no queued read", 32'(bus_rd), 32'd0);
        req[3] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8", "still idle", 32'(bus_rd), 32'd0);
        cfg_read(2'd2, rv);
        chk("R8", "one unit for busy edge", 32'(rv), 32'd3);

        // Writes while armed have no effect beyond arm (R9)
        cfg_write(2'd0, 16'h7777);
        cfg_read(2'd0, rv);
        chk("R9", "pointer locked", 32'(rv), 32'h5002);
        cfg_write(2'd2, 16'd9);
        cfg_read(2'd2, rv);
        chk("R9", "count locked", 32'(rv), 32'd3);
        cfg_write(2'd3, ctrl_word(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 1'b0));
        cfg_read(2'd3, rv);
        chk("R9", "size bit locked", 32'(rv[4]), 32'd0);
        cfg_write(2'd3, ctrl_word(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 1'b0));
        cfg_read(2'd3, rv);
        chk("R9", "arm bit still writable", 32'(rv[0]), 32'd0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule